// File: doc/BRIEF.md
# Auxiliary-Channel Interrupt Status Register

This block is a memory-mapped interrupt register for an auxiliary-channel link controller. Six hardware event pulses are caught in sticky status bits: transfer complete, bad address, timeout, negative acknowledge or defer, bad byte count, and generic channel error. Each event owns three bits in one 32-bit word: its status bit at a fixed position, an acknowledge bit one place above it, and an interrupt-enable bit two places above it. One write can therefore clear several pending events and arm several interrupt sources at the same time.

Software treats any of the five error events, or transfer complete, as the end of a transaction. It typically arms and clears everything in one write before starting a transfer, waits for the interrupt line, then clears with an acknowledge-only write that must leave the stored enables alone. A second register returns a fixed revision value. There is no state machine: the block is six identical event cells, a write decoder and a read multiplexer.

Top module: `auxirq_status_reg`

## Requirements
- R1: After reset every status bit and every enable bit is 0, the status word reads 0x0000_0000 and `irq_o` is 0.
- R2: A 1 on `evt_i[k]` in a cycle sets status bit P(k) of the status word from the next cycle, and it stays set until acknowledged. Event index k=0..5 maps to positions P = 3, 6, 9, 12, 15, 27 (complete, bad address, timeout, nack/defer, bad count, channel error).
- R3: A write to offset 0x20 with bit P(k)+1 set clears status bit P(k) from the next cycle; status bits whose acknowledge bit is 0 in that write are unchanged.
- R4: When `evt_i[k]` is 1 in the same cycle as its acknowledge, the status bit is 1 afterwards.
- R5: A write to offset 0x20 in which at least one enable position P(k)+2 is 1 loads all six enables from bits P(k)+2, and each enable reads back at P(k)+2.
- R6: A write to offset 0x20 with all six enable positions at 0 leaves every stored enable unchanged.
- R7: In the status word, acknowledge positions P(k)+1 and every bit not at a P(k) or P(k)+2 position read 0.
- R8: `irq_o` is 1 exactly when some event k has both its status bit and its enable set.
- R9: Reads at offset 0x00 return the parameter `REV_VALUE` (default 0x1000_0004); reads at any offset other than 0x00 and 0x20 return 0, and writes to them change nothing.
- R10: One write to 0x20 carrying acknowledge bits and enable bits performs both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset for read and write |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| evt_i | input | 6 | Event pulses, index order complete, bad address, timeout, nack/defer, bad count, channel error |
| irq_o | output | 1 | Level interrupt |

## Verification
Single events fired one by one show that each lands at its own position and nowhere else. Acknowledge-only writes, enable-only writes and combined writes are tried against a set of pending events, which separates clearing from arming and shows an acknowledge-only write keeping the enables. An event arriving in the same cycle as its own acknowledge shows which side wins. A long seeded random mix of pulses, writes to the status word, the revision word and an unused offset is compared against a bench model of status, enables and interrupt. This catches crosstalk between neighbouring bit fields and stray decodes.

// File: rtl/auxirq_pkg.sv
package auxirq_pkg;
    localparam int unsigned EVT_COUNT  = 6;
    localparam int unsigned ACK_SHIFT  = 1;
    localparam int unsigned MASK_SHIFT = 2;

    // Status bit position of each event index in the status word.
    function automatic int unsigned evt_pos(input int unsigned idx);
        case (idx)
            0:       return 3;   // transfer complete
            1:       return 6;   // bad address
            2:       return 9;   // timeout
            3:       return 12;  // nack / defer
            4:       return 15;  // bad byte count
            default: return 27;  // channel error
        endcase
    endfunction
endpackage

// File: rtl/auxirq_evt_cell.sv
module auxirq_evt_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ack_i,
    input  logic load_en_i,
    input  logic en_val_i,
    output logic status_o,
    output logic en_o
);
    logic status_q;
    logic en_q;

    // Sticky status: a new event outranks a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= evt_i | (status_q & ~ack_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (load_en_i) begin
            en_q <= en_val_i;
        end
    end

    assign status_o = status_q;
    assign en_o     = en_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> status_q); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !ack_i) |=> status_q); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !evt_i) |=> !status_q); // R3
    AST_EVT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && evt_i) |=> status_q); // R4
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en_i |=> $stable(en_q)); // R6
endmodule

// File: rtl/auxirq_readback.sv
module auxirq_readback
    import auxirq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] REV_OFS    = 8'h00,
    parameter logic [DATA_W-1:0] REV_VALUE  = 32'h1000_0004
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [EVT_COUNT-1:0] status_i,
    input  logic [EVT_COUNT-1:0] en_i,
    output logic [DATA_W-1:0]    rdata_o
);
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word = '0;
        for (int k = 0; k < EVT_COUNT; k++) begin
            status_word[evt_pos(k)]              = status_i[k];
            status_word[evt_pos(k) + MASK_SHIFT] = en_i[k];
        end
    end

    always_comb begin
        if (addr_i == STATUS_OFS) begin
            rdata_o = status_word;
        end else if (addr_i == REV_OFS) begin
            rdata_o = REV_VALUE;
        end else begin
            rdata_o = '0;
        end
    end
endmodule

// File: rtl/auxirq_status_reg.sv
module auxirq_status_reg
    import auxirq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] REV_OFS    = 8'h00,
    parameter logic [DATA_W-1:0] REV_VALUE  = 32'h1000_0004
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [EVT_COUNT-1:0] evt_i,
    output logic                 irq_o
);
    logic                 status_hit;
    logic                 mask_field_set;
    logic [EVT_COUNT-1:0] status_vec;
    logic [EVT_COUNT-1:0] en_vec;

    assign status_hit = bus_wr && (bus_addr == STATUS_OFS);

    // The enable set is reloaded only by writes that carry an enable bit.
    always_comb begin
        mask_field_set = 1'b0;
        for (int k = 0; k < EVT_COUNT; k++) begin
            mask_field_set = mask_field_set | bus_wdata[evt_pos(k) + MASK_SHIFT];
        end
    end

    for (genvar g = 0; g < EVT_COUNT; g++) begin : g_evt
        localparam int unsigned P = evt_pos(g);
        auxirq_evt_cell i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[g]),
            .ack_i     (status_hit && bus_wdata[P + ACK_SHIFT]),
            .load_en_i (status_hit && mask_field_set),
            .en_val_i  (bus_wdata[P + MASK_SHIFT]),
            .status_o  (status_vec[g]),
            .en_o      (en_vec[g])
        );
    end

    auxirq_readback #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STATUS_OFS (STATUS_OFS),
        .REV_OFS    (REV_OFS),
        .REV_VALUE  (REV_VALUE)
    ) i_readback (
        .addr_i   (bus_addr),
        .status_i (status_vec),
        .en_i     (en_vec),
        .rdata_o  (bus_rdata)
    );

    assign irq_o = |(status_vec & en_vec);

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_vec != '0)); // R8
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq_o); // R8
    AST_REV_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REV_OFS) |-> (bus_rdata == REV_VALUE)); // R9
    AST_OTHER_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != STATUS_OFS && evt_i == '0) |=> $stable(en_vec)); // R9
endmodule

// File: tb/test_auxirq_status_reg.sv
module test_auxirq_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REV = 32'h1000_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h20;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [5:0] m_st = '0;
    logic [5:0] m_en = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    auxirq_status_reg i_auxirq_status_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    function automatic int pos(input int k);
        case (k)
            0: return 3;  1: return 6;  2: return 9;
            3: return 12; 4: return 15; default: return 27;
        endcase
    endfunction

    function automatic logic [31:0] word_of(input logic [5:0] st, input logic [5:0] en);
        logic [31:0] w = '0;
        for (int k = 0; k < 6; k++) begin
            w[pos(k)] = st[k];
            w[pos(k) + 2] = en[k];
        end
        return w;
    endfunction

    function automatic logic [31:0] ack_bits(input logic [5:0] a);
        logic [31:0] w = '0;
        for (int k = 0; k < 6; k++) w[pos(k) + 1] = a[k];
        return w;
    endfunction

    function automatic logic [31:0] en_bits(input logic [5:0] e);
        logic [31:0] w = '0;
        for (int k = 0; k < 6; k++) w[pos(k) + 2] = e[k];
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model at the rising edge.
    task automatic cycle(input logic [7:0] a, input logic wr, input logic [31:0] wd, input logic [5:0] ev);
        logic mask_any;
        bus_addr = a; bus_wr = wr; bus_wdata = wd; evt_i = ev;
        @(posedge clk);
        mask_any = 1'b0;
        for (int k = 0; k < 6; k++) mask_any = mask_any | wd[pos(k) + 2];
        for (int k = 0; k < 6; k++) begin
            m_st[k] = ev[k] | (m_st[k] & ~(wr && a == 8'h20 && wd[pos(k) + 1]));
            if (wr && a == 8'h20 && mask_any) m_en[k] = wd[pos(k) + 2];
        end
        @(negedge clk);
        bus_wr = 1'b0; evt_i = '0;
    endtask

    task automatic check_state(input string req);
        bus_addr = 8'h20; #1;
        check(req, bus_rdata, word_of(m_st, m_en));
        check({req, "/R8"}, {31'd0, irq_o}, {31'd0, |(m_st & m_en)});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", bus_rdata, 32'h0);
        check("R1", {31'd0, irq_o}, 32'h0);

        // R2: each event alone lands at its own position
        for (int k = 0; k < 6; k++) begin
            cycle(8'h20, 1'b0, '0, 6'b1 << k);
            check_state("R2");
        end
        cycle(8'h20, 1'b0, '0, '0);
        check_state("R2 sticky");

        // R3: acknowledge timeout only; R6 enables untouched (still 0)
        cycle(8'h20, 1'b1, ack_bits(6'b000100), '0);
        check_state("R3");
        check("R3", bus_rdata & (32'h1 << 9), 32'h0);

        // R4: bad-count event with its own acknowledge
        cycle(8'h20, 1'b1, ack_bits(6'b010000), 6'b010000);
        check_state("R4");
        check("R4", bus_rdata & (32'h1 << 15), 32'h1 << 15);

        // R5: arm complete and channel error
        cycle(8'h20, 1'b1, en_bits(6'b100001), '0);
        check_state("R5");
        check("R8", {31'd0, irq_o}, 32'h1);

        // R6: acknowledge-only write keeps enables; R8 irq drops
        cycle(8'h20, 1'b1, ack_bits(6'b111111), '0);
        check_state("R6");
        check("R6", bus_rdata, en_bits(6'b100001));
        check("R8", {31'd0, irq_o}, 32'h0);

        // R7: all-ones write reads back enables only
        cycle(8'h20, 1'b1, 32'hFFFF_FFFF, 6'b000010);
        check_state("R7");
        check("R7", bus_rdata, word_of(6'b000010, 6'b111111));

        // R9: revision word, unused offset, write elsewhere
        bus_addr = 8'h00; #1;
        check("R9", bus_rdata, REV);
        bus_addr = 8'h24; #1;
        check("R9", bus_rdata, 32'h0);
        cycle(8'h24, 1'b1, 32'hFFFF_FFFF, '0);
        cycle(8'h00, 1'b1, 32'h0000_0000, '0);
        check_state("R9");

        // R10: combined acknowledge and arm
        cycle(8'h20, 1'b0, '0, 6'b011100);
        cycle(8'h20, 1'b1, ack_bits(6'b001010) | en_bits(6'b000100), '0);
        check_state("R10");
        check("R10", bus_rdata, word_of(6'b010100, 6'b000100));

        // Seeded random mix
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            logic [31:0] wd;
            int sel = $urandom % 8;
            a = (sel < 6) ? 8'h20 : ((sel == 6) ? 8'h00 : 8'h24);
            wd = ($urandom % 3 == 0) ? ack_bits(6'($urandom)) : $urandom;
            cycle(a, ($urandom % 2) == 1, wd, 6'($urandom) & 6'($urandom));
            check_state("R2/R3/R5 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule